// File: doc/BRIEF.md
# Register-Driven Two-Wire EEPROM Emulator

This block stands in for a 128-byte two-wire serial EEPROM. The host toggles the clock and data lines itself, one CPU register write per line change. A single control register holds the clock level, the data level and a direction bit. When the host reads, the EEPROM's data-out bit is returned on one lane of a memory-mapped read window.

Inside, the block watches the latched lines for start and stop conditions and for clock edges. The first byte after a start holds a 7-bit word address and a read/write flag. The block then either takes in data bytes and stores them, or sends stored bytes out. Bits go most-significant first. The device drives an acknowledge after every byte it receives. The word address steps by one after each byte and wraps at the top of the array.

Top module: `eeprom_bitbang`

## Requirements
- R1: A CPU write whose address ANDed with 16'h800F equals 16'h800D latches data bit 5 as the clock line, bit 6 as the data line and bit 7 as the direction bit. Writes to any other address leave all three unchanged.
- R2: A CPU read whose address ANDed with 16'hE000 equals 16'h6000 drives only bit 4 (`rd_drive` = 8'h10), and `rd_data[4]` carries the data-out value. Any other read, or no read, gives `rd_drive` = 0.
- R3: Data-out reads as 1 when the direction bit is 0, and also when the device is not driving the line (idle, receiving, after a no-acknowledge).
- R4: A data falling edge while the clock stays high is a start. It aborts any transfer in progress and begins a new address byte. A data rising edge while the clock stays high is a stop, and it returns the device to idle.
- R5: The first byte after a start carries the word address in bits 7:1 and a flag in bit 0, where 1 means read and 0 means write.
- R6: After each byte it receives (address or write data), the device drives data-out low from the clock fall after the eighth bit until the next clock fall.
- R7: Bytes are shifted most-significant bit first, both in and out. A read bit is valid while the clock is high.
- R8: After each data byte written or sent, the word address increments modulo 128.
- R9: During a read, a master acknowledge (data 0 on the ninth clock) starts the next byte. A no-acknowledge (data 1) leaves the line released until the next start or stop.
- R10: After reset the device is idle, the latched clock and data lines are high, and the direction bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| rd_data | output | 8 | Read data; only the lanes set in rd_drive are meaningful |
| rd_drive | output | 8 | Per-bit drive enable for rd_data (0 means open bus) |

## Verification
The bench first writes a three-byte burst and then reads it back. Reading the bytes in order separates MSB-first shifting from LSB-first shifting, and the per-byte auto-increment from a fixed address. A burst that starts at word 127 shows whether the address wraps to 0. A write that is cut short by a repeated start, followed by a read of the same word, shows whether a start aborts the transfer. During the acknowledge window the bench toggles the direction bit through both a decoded and a non-decoded address. This tells the data-out masking apart from a failure of the address decode.

// File: rtl/eeprom_bitbang.sv
module eeprom_bitbang #(
  parameter int          DW        = 8,
  parameter logic [15:0] CTRL_ADDR = 16'h800D,
  parameter logic [15:0] CTRL_MASK = 16'h800F,
  parameter logic [15:0] WIN_BASE  = 16'h6000,
  parameter logic [15:0] WIN_MASK  = 16'hE000,
  parameter int          SCL_BIT   = 5,
  parameter int          SDA_BIT   = 6,
  parameter int          DIR_BIT   = 7,
  parameter int          DOUT_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic          cpu_rd,
  input  logic [15:0]   cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] rd_drive
);
  localparam int AW    = DW - 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(DW);

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXA, S_TX, S_TXE, S_TXA, S_TXL, S_WAIT
  } st_t;

  st_t           st;
  logic          scl_q, sda_q, dir_q;
  logic          is_addr, rw, ackon;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sr;
  logic [AW-1:0] addr;
  logic [DW-1:0] mem [DEPTH];

  logic ctrl_wr, scl_n, sda_n, rise, fall, start_ev, stop_ev;
  logic last_bit, data_wr, sda_out, dout, rd_hit;

  assign ctrl_wr  = cpu_we && ((cpu_addr & CTRL_MASK) == CTRL_ADDR);
  assign scl_n    = ctrl_wr ? cpu_wdata[SCL_BIT] : scl_q;
  assign sda_n    = ctrl_wr ? cpu_wdata[SDA_BIT] : sda_q;
  assign rise     = !scl_q && scl_n;
  assign fall     = scl_q && !scl_n;
  assign start_ev = scl_q && scl_n && sda_q && !sda_n;
  assign stop_ev  = scl_q && scl_n && !sda_q && sda_n;
  assign last_bit = rise && (cnt == CW'(DW - 1));
  assign data_wr  = (st == S_RX) && last_bit && !is_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      dir_q   <= 1'b0;
      is_addr <= 1'b0;
      rw      <= 1'b0;
      ackon   <= 1'b0;
      cnt     <= '0;
      sr      <= '1;
      addr    <= '0;
    end else begin
      if (ctrl_wr) begin
        scl_q <= cpu_wdata[SCL_BIT];
        sda_q <= cpu_wdata[SDA_BIT];
        dir_q <= cpu_wdata[DIR_BIT];
      end
      if (start_ev) begin
        st      <= S_RX;
        cnt     <= '0;
        is_addr <= 1'b1;
        ackon   <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_RX: if (rise) begin
            sr  <= {sr[DW-2:0], sda_n};
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              st    <= S_RXA;
              ackon <= 1'b0;
              if (is_addr) begin
                addr <= sr[AW-1:0];
                rw   <= sda_n;
              end else begin
                addr <= addr + 1'b1;
              end
            end
          end
          S_RXA: if (fall) begin
            if (!ackon) ackon <= 1'b1;
            else begin
              ackon   <= 1'b0;
              is_addr <= 1'b0;
              cnt     <= '0;
              if (rw) begin
                st <= S_TX;
                sr <= mem[addr];
              end else begin
                st <= S_RX;
              end
            end
          end
          S_TX: if (rise) begin
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              st   <= S_TXE;
              addr <= addr + 1'b1;
            end
          end else if (fall) begin
            sr <= {sr[DW-2:0], 1'b1};
          end
          S_TXE: if (fall) st <= S_TXA;
          S_TXA: if (rise) st <= sda_n ? S_WAIT : S_TXL;
          S_TXL: if (fall) begin
            st  <= S_TX;
            sr  <= mem[addr];
            cnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (data_wr && !start_ev) mem[addr] <= {sr[DW-2:0], sda_n};

  assign sda_out = (st == S_RXA && ackon)       ? 1'b0 :
                   (st == S_TX || st == S_TXE)  ? sr[DW-1] : 1'b1;
  assign dout    = dir_q ? sda_out : 1'b1;
  assign rd_hit  = cpu_rd && ((cpu_addr & WIN_MASK) == WIN_BASE);

  always_comb begin
    rd_data  = '0;
    rd_drive = '0;
    if (rd_hit) begin
      rd_data[DOUT_BIT]  = dout;
      rd_drive[DOUT_BIT] = 1'b1;
    end
  end

  AST_START_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == S_RX && cnt == '0 && is_addr));  // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> st == S_IDLE);  // R4
  AST_BYTE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && last_bit) |=> (st == S_RXA && !ackon));  // R6
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> addr == AW'($past(addr) + 1'b1));  // R8
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TXA && rise && sda_n) |=> st == S_WAIT);  // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_WAIT) |-> dout);  // R3
endmodule

// File: tb/tb_eeprom_bitbang.sv
module tb_eeprom_bitbang;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cpu_we = 1'b0, cpu_rd = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  rd_data, rd_drive;

  eeprom_bitbang dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always #(CLK_P/2) clk = ~clk;

  int    checks = 0, errors = 0;
  int    exp_q[$], got_q[$];
  string tag_q[$];
  bit    cur_dir = 1'b0;
  bit    done = 1'b0;

  always @(negedge clk) begin
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      int e, g;
      string t;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (e != g) begin
        errors++;
        $display("FAIL %s got %0h exp %0h", t, g, e);
      end
    end
  end

  task automatic expect_item(string t, int e);
    tag_q.push_back(t);
    exp_q.push_back(e);
  endtask

  task automatic ctl_at(input logic [15:0] a, input bit c, input bit d, input bit dr);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = {dr, d, c, 5'b0};
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic ctl(input bit c, input bit d);
    ctl_at(16'h800D, c, d, cur_dir);
  endtask

  task automatic rd_at(input logic [15:0] a, output logic [7:0] dv, output logic [7:0] mv);
    cpu_rd = 1'b1; cpu_addr = a;
    #1;
    dv = rd_data; mv = rd_drive;
    cpu_rd = 1'b0;
  endtask

  task automatic rdbit(output bit b);
    logic [7:0] dv, mv;
    rd_at(16'h6000, dv, mv);
    b = dv[4];
  endtask

  task automatic i2c_start; ctl(1, 1); ctl(1, 0); ctl(0, 0); endtask
  task automatic i2c_stop;  ctl(0, 0); ctl(1, 0); ctl(1, 1); endtask
  task automatic sendbit(input bit b); ctl(0, b); ctl(1, b); ctl(0, b); endtask

  task automatic sendbyte(input logic [7:0] x, input string t);
    bit b;
    for (int i = 7; i >= 0; i--) sendbit(x[i]);
    ctl(0, 1); ctl(1, 1);
    expect_item(t, 0);
    rdbit(b); got_q.push_back(int'(b));
    ctl(0, 1);
  endtask

  task automatic recvbyte(input logic [7:0] e, input bit ack, input string t);
    logic [7:0] v;
    bit b;
    for (int i = 7; i >= 0; i--) begin
      ctl(1, 1); rdbit(b); v[i] = b; ctl(0, 1);
    end
    expect_item(t, int'(e));
    got_q.push_back(int'(v));
    ctl(0, !ack); ctl(1, !ack); ctl(0, !ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] dv, mv;
    bit b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 / R3: reset leaves direction 0, data-out released
    expect_item("R10", 1); rdbit(b); got_q.push_back(int'(b));
    // R2: window decode and drive mask
    rd_at(16'h7FFF, dv, mv); expect_item("R2", 8'h10); got_q.push_back(int'(mv));
    rd_at(16'h5FFF, dv, mv); expect_item("R2", 0);     got_q.push_back(int'(mv));
    rd_at(16'h8000, dv, mv); expect_item("R2", 0);     got_q.push_back(int'(mv));

    cur_dir = 1'b1;
    ctl(1, 1);

    // R5 / R6 / R8: burst write at word 5
    i2c_start;
    sendbyte({7'h05, 1'b0}, "R5");
    sendbyte(8'hA5, "R6");
    sendbyte(8'h3C, "R6");
    sendbyte(8'h7F, "R6");
    i2c_stop;

    // R7 / R8 / R9: burst read from word 5
    i2c_start;
    sendbyte({7'h05, 1'b1}, "R5");
    recvbyte(8'hA5, 1, "R7");
    recvbyte(8'h3C, 1, "R8");
    recvbyte(8'h7F, 0, "R9");
    ctl(1, 1); expect_item("R9", 1); rdbit(b); got_q.push_back(int'(b));
    ctl(0, 1);
    i2c_stop;

    // R8: wrap from 127 to 0
    i2c_start;
    sendbyte({7'h7F, 1'b0}, "R5");
    sendbyte(8'h11, "R6");
    sendbyte(8'h22, "R6");
    i2c_stop;
    i2c_start;
    sendbyte({7'h7F, 1'b1}, "R5");
    recvbyte(8'h11, 1, "R8");
    recvbyte(8'h22, 0, "R8");
    i2c_stop;

    // R4: start aborts a partial write
    i2c_start;
    sendbyte({7'h10, 1'b0}, "R5");
    sendbyte(8'h99, "R6");
    i2c_stop;
    i2c_start;
    sendbyte({7'h10, 1'b0}, "R5");
    for (int i = 0; i < 4; i++) sendbit(1'b0);
    i2c_start;
    sendbyte({7'h10, 1'b1}, "R4");
    recvbyte(8'h99, 0, "R4");
    i2c_stop;

    // R1 / R3: direction masking and control address decode, during an ack
    i2c_start;
    for (int i = 7; i >= 0; i--) sendbit(i == 0 ? 1'b0 : 1'b1);
    ctl(0, 1); ctl(1, 1);
    expect_item("R6", 0); rdbit(b); got_q.push_back(int'(b));
    ctl_at(16'h800D, 1, 1, 0);
    expect_item("R3", 1); rdbit(b); got_q.push_back(int'(b));
    ctl_at(16'h800E, 1, 1, 1);
    expect_item("R1", 1); rdbit(b); got_q.push_back(int'(b));
    ctl_at(16'h9FFD, 1, 1, 1);
    expect_item("R1", 0); rdbit(b); got_q.push_back(int'(b));
    ctl(0, 1);
    i2c_stop;

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule